// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block lets a synchronous host read and write single bytes in an asynchronous static memory. The memory has a 13-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip enable, write enable and output enable. The host presents an address, a read/write flag and write data on a request/ready port. For reads, the byte comes back with a one-cycle valid pulse.

Each strobe interval is a number of clock cycles. The block derives these counts at elaboration from nanosecond timing parameters and the clock period, always rounding up with a minimum of one cycle. A write keeps chip enable low for the whole access and shapes the write pulse with write enable. Address setup, the write pulse, address/data hold and the idle gap between accesses are separate counted phases. A read lowers chip enable and output enable together, waits the access time and captures the bus on the edge that ends the access.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, and at once when it is asserted asynchronously mid-access, all three strobes are high (inactive), the data bus is not driven and ready is low. Ready goes high within four clock edges after reset is released.
- R2: A request is taken only on a clock edge where both req_valid and req_ready are high. Ready is low from the next cycle until the access and its gap have finished. While ready is high, no strobe is active.
- R3: A write lowers chip enable with write enable high for SU = ceil(T_SETUP_NS/CLK_NS) cycles. Write enable is then low for WP = max(ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS)) cycles. Write enable is never low while chip enable is high.
- R4: After write enable rises, chip enable stays low for HC cycles. HC is max(ceil(T_AH_NS/CLK_NS), ceil(T_DH_NS/CLK_NS)), raised when needed so that SU+WP+HC is at least ceil(T_WC_NS/CLK_NS).
- R5: Output enable stays high during a write. The controller drives the bus only while output enable is high. During a write the bus carries the request's write data for every cycle that chip enable is low.
- R6: Whenever chip enable is low, mem_addr equals the address captured with the request and does not change.
- R7: A read holds chip enable and output enable low together, with write enable high, for AC = ceil(T_ACC_NS/CLK_NS) cycles. The bus is captured on the edge that ends them. rd_valid is high for exactly one cycle, with that byte on rd_data.
- R8: Every access is followed by TC = ceil(T_TURN_NS/CLK_NS) cycles with all strobes high before ready returns. This puts at least one idle cycle between a read and a following write.
- R9: rd_valid never pulses for a write, and only follows a cycle in which output enable was low.
- R10: Changes on the request inputs while ready is low, including a still-high req_valid, have no effect. The access uses the address, data and direction taken at acceptance, and exactly one memory write happens per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | DATA_W | Byte captured by the last read |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | inout | DATA_W | Tri-stated memory data bus |

## Verification
The bench sets a 20 ns clock (CLK_NS=20), T_WC_NS=160 and T_TURN_NS=20, and keeps the other timings at their defaults. This gives SU=1, WP=4, AC=5 and TC=1. The base hold of one cycle is padded to HC=3 so that the write reaches eight cycles, which exercises the hold padding that the default 10 ns clock never uses. A small memory model in the bench checks that each write lands once with the right address and data. It also checks that reads return what was stored, including across a read followed directly by a write.

// File: rtl/srctl_pkg.sv
package srctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WSET  = 3'd1,
    PH_WLOW  = 3'd2,
    PH_WHOLD = 3'd3,
    PH_RACC  = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = len - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sample,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  inout  wire  [DATA_W-1:0] mem_dq
);

  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  assign mem_dq = drv_en ? wdata : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= sample;
      if (sample) begin
        rd_data_q <= mem_dq;
      end
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import srctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned T_SETUP_NS = 10,
  parameter int unsigned T_WP_NS    = 80,
  parameter int unsigned T_DS_NS    = 50,
  parameter int unsigned T_AH_NS    = 10,
  parameter int unsigned T_DH_NS    = 5,
  parameter int unsigned T_WC_NS    = 100,
  parameter int unsigned T_ACC_NS   = 100,
  parameter int unsigned T_TURN_NS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  // Phase lengths in cycles
  localparam int unsigned SU_CYC = ns_to_cyc(T_SETUP_NS, CLK_NS);
  localparam int unsigned WP_CYC = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int unsigned HB_CYC = max2(ns_to_cyc(T_AH_NS, CLK_NS), ns_to_cyc(T_DH_NS, CLK_NS));
  localparam int unsigned WC_CYC = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned HC_CYC = (SU_CYC + WP_CYC + HB_CYC >= WC_CYC) ? HB_CYC
                                   : (WC_CYC - SU_CYC - WP_CYC);
  localparam int unsigned AC_CYC = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int unsigned TC_CYC = ns_to_cyc(T_TURN_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max2(max2(max2(SU_CYC, WP_CYC), max2(HC_CYC, AC_CYC)), TC_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic rst_s_n;

  sram_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  phase_e            st_q, st_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_len;
  logic              tmr_last;
  logic              take;
  logic              grab;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  // Next-phase logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    take     = 1'b0;
    grab     = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (req_valid && req_ready) begin
          take     = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            st_d    = PH_WSET;
            tmr_len = CNT_W'(SU_CYC);
          end else begin
            st_d    = PH_RACC;
            tmr_len = CNT_W'(AC_CYC);
          end
        end
      end
      PH_WSET: begin
        if (tmr_last) begin
          st_d     = PH_WLOW;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(WP_CYC);
        end
      end
      PH_WLOW: begin
        if (tmr_last) begin
          st_d     = PH_WHOLD;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(HC_CYC);
        end
      end
      PH_WHOLD: begin
        if (tmr_last) begin
          st_d     = PH_GAP;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(TC_CYC);
        end
      end
      PH_RACC: begin
        if (tmr_last) begin
          st_d     = PH_GAP;
          grab     = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(TC_CYC);
        end
      end
      PH_GAP: begin
        if (tmr_last) begin
          st_d = PH_IDLE;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  // Registered strobes follow the next phase so they leave flops cleanly
  logic ce_d, we_d, oe_d, drv_d, rdy_d;
  logic ce_n_q, we_n_q, oe_n_q, drv_q, rdy_q;

  always_comb begin
    ce_d  = (st_d == PH_WSET) || (st_d == PH_WLOW) || (st_d == PH_WHOLD) || (st_d == PH_RACC);
    we_d  = (st_d == PH_WLOW);
    oe_d  = (st_d == PH_RACC);
    drv_d = (st_d == PH_WSET) || (st_d == PH_WLOW) || (st_d == PH_WHOLD);
    rdy_d = (st_d == PH_IDLE);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= PH_IDLE;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      drv_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ce_n_q <= ~ce_d;
      we_n_q <= ~we_d;
      oe_n_q <= ~oe_d;
      drv_q  <= drv_d;
      rdy_q  <= rdy_d;
    end
  end

  // Request capture, clock-enabled by acceptance
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (take) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  sram_dq_port #(.DATA_W(DATA_W)) u_dq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .drv_en   (drv_q),
    .wdata    (wdat_q),
    .sample   (grab),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .mem_dq   (mem_dq)
  );

  assign req_ready = rdy_q;
  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              drv_en
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !drv_en));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_hold_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> mem_oe_n);

  p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> drv_en);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_read_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  p_rdv_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_gap_after_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> !req_ready);

  p_rdv_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_addr  (mem_addr),
  .drv_en    (drv_q)
);

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb;

  localparam int CLK_NS = 20;

  function automatic int cdiv(input int t, input int c);
    int r;
    r = (t + c - 1) / c;
    return (r < 1) ? 1 : r;
  endfunction

  localparam int E_SU = cdiv(10, CLK_NS);
  localparam int E_WP = (cdiv(80, CLK_NS) > cdiv(50, CLK_NS)) ? cdiv(80, CLK_NS) : cdiv(50, CLK_NS);
  localparam int E_HB = (cdiv(10, CLK_NS) > cdiv(5, CLK_NS)) ? cdiv(10, CLK_NS) : cdiv(5, CLK_NS);
  localparam int E_WC = cdiv(160, CLK_NS);
  localparam int E_HC = (E_SU + E_WP + E_HB >= E_WC) ? E_HB : (E_WC - E_SU - E_WP);
  localparam int E_AC = cdiv(100, CLK_NS);
  localparam int E_TC = cdiv(20, CLK_NS);

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [12:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  wire  [7:0]  mem_dq;

  sram_strobe_ctrl #(
    .CLK_NS    (CLK_NS),
    .T_WC_NS   (160),
    .T_TURN_NS (20)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq    (mem_dq)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // Memory model: 256 bytes indexed by the low address byte
  logic [7:0]  store [256];
  int          wr_cnt;
  logic [12:0] last_wa;
  logic [7:0]  last_wd;
  logic        mdl_drive;

  assign mdl_drive = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq    = mdl_drive ? store[mem_addr[7:0]] : 8'bz;

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      store[mem_addr[7:0]] = mem_dq;
      wr_cnt  = wr_cnt + 1;
      last_wa = mem_addr;
      last_wd = mem_dq;
    end
  end

  int total;
  int bad;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  task automatic wait_ready();
    for (int g = 0; g < 60 && !req_ready; g++) @(negedge clk);
  endtask

  task automatic do_access(input bit w, input logic [12:0] a, input logic [7:0] d, input logic [7:0] e);
    int busy, pre, wlo, post, acc, oelo, gap, rdv, admis, dqmis, wr0, g;
    logic [7:0] rdat;
    bit seen;
    busy = 0; pre = 0; wlo = 0; post = 0; acc = 0; oelo = 0; gap = 0;
    rdv = 0; admis = 0; dqmis = 0; seen = 0; rdat = 8'h00; g = 0;
    wait_ready();
    wr0 = wr_cnt;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    // R10: keep a different request pending while busy
    req_write = ~w; req_addr = ~a; req_wdata = ~d;
    while (!req_ready && g < 60) begin
      busy++;
      if (!mem_ce_n && mem_addr != a) admis++;
      if (!mem_oe_n) oelo++;
      if (w && !mem_ce_n && mem_dq != d) dqmis++;
      if (mem_ce_n) gap++;
      else if (!mem_we_n) begin wlo++; seen = 1'b1; end
      else if (!mem_oe_n) acc++;
      else if (seen) post++;
      else pre++;
      if (rd_valid) begin rdv++; rdat = rd_data; end
      g++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (w) begin
      chk(busy == E_SU + E_WP + E_HC + E_TC, "R2", "write busy cycles", busy, E_SU + E_WP + E_HC + E_TC);
      chk(pre == E_SU, "R3", "setup cycles", pre, E_SU);
      chk(wlo == E_WP, "R3", "write pulse cycles", wlo, E_WP);
      chk(post == E_HC, "R4", "hold cycles", post, E_HC);
      chk(oelo == 0, "R5", "oe low in write", oelo, 0);
      chk(dqmis == 0, "R5", "bus data mismatches", dqmis, 0);
      chk(rdv == 0, "R9", "rd_valid in write", rdv, 0);
      chk(wr_cnt - wr0 == 1, "R10", "memory writes", wr_cnt - wr0, 1);
      chk(last_wa == a, "R10", "written address", int'(last_wa), int'(a));
      chk(last_wd == d, "R10", "written data", int'(last_wd), int'(d));
    end else begin
      chk(busy == E_AC + E_TC, "R2", "read busy cycles", busy, E_AC + E_TC);
      chk(acc == E_AC, "R7", "access cycles", acc, E_AC);
      chk(oelo == E_AC, "R7", "oe low cycles", oelo, E_AC);
      chk(wlo == 0, "R7", "we low in read", wlo, 0);
      chk(rdv == 1, "R7", "rd_valid pulses", rdv, 1);
      chk(rdat == e, "R7", "read data", int'(rdat), int'(e));
      chk(wr_cnt == wr0, "R10", "memory writes in read", wr_cnt - wr0, 0);
    end
    chk(admis == 0, "R6", "address mismatches", admis, 0);
    chk(gap == E_TC, "R8", "gap cycles", gap, E_TC);
  endtask

  // {write, addr, wdata, expected read}
  localparam logic [29:0] VEC [9] = '{
    {1'b1, 13'h0012, 8'h5A, 8'h00},
    {1'b0, 13'h0012, 8'h00, 8'h5A},
    {1'b1, 13'h1FFF, 8'hC3, 8'h00},
    {1'b1, 13'h0000, 8'h3C, 8'h00},
    {1'b0, 13'h1FFF, 8'h00, 8'hC3},
    {1'b0, 13'h0000, 8'h00, 8'h3C},
    {1'b0, 13'h0A77, 8'h00, 8'hD2},
    {1'b1, 13'h0A77, 8'hFF, 8'h00},
    {1'b0, 13'h0A77, 8'h00, 8'hFF}
  };

  initial begin
    int n;
    int q;
    total = 0; bad = 0; wr_cnt = 0; last_wa = '0; last_wd = '0;
    for (int i = 0; i < 256; i++) store[i] = 8'(i) ^ 8'hA5;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!req_ready, "R1", "ready in reset", req_ready, 0);
    chk(!rd_valid, "R1", "rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 10) begin @(negedge clk); n++; end
    chk(n <= 4, "R1", "edges until ready", n, 4);

    // R2: no request, no strobe activity
    q = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!mem_ce_n || !mem_we_n || !mem_oe_n || !req_ready) q++;
    end
    chk(q == 0, "R2", "activity while idle", q, 0);

    for (int i = 0; i < 9; i++) begin
      do_access(VEC[i][29], VEC[i][28:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R1: asynchronous reset in the middle of a write pulse
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0155; req_wdata = 8'h99;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_we_n, "R3", "write pulse before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes on async reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!req_ready, "R1", "ready on async reset", req_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 10) begin @(negedge clk); n++; end
    chk(n <= 4, "R1", "edges until ready after abort", n, 4);

    do_access(1'b1, 13'h0155, 8'h66, 8'h00);
    do_access(1'b0, 13'h0155, 8'h00, 8'h66);

    finish_up();
  end

endmodule